// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the access address for a synchronous burst memory that moves data in groups of four beats. On each rising clock edge it either captures a new external base address, steps to the next beat of the current group, or holds the present beat as a wait cycle. Only the two lowest address bits are sequenced. The upper bits keep the value captured at load time for as long as the group is in use.

Two strobes can start a group. The first is gated by a bank enable. The second is not gated. A separate active-low advance input steps the beat. When advance is high the address is frozen, and the burst is not ended. A mode input chooses the beat order. It is either an XOR interleave of the start value with the beat count, or an up-count modulo four from the start value. The mode is applied combinationally to the address that is currently registered.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `access_addr` and `beat_idx` are both zero. They become zero as soon as reset is asserted, without waiting for a clock edge.
- R2: A clock edge with `proc_strobe_n` low and `bank_sel_n` low captures `ext_addr`. After that edge `beat_idx` is 0 and `access_addr` equals the captured address, in either mode.
- R3: When `proc_strobe_n` is low but `bank_sel_n` is high, the processor strobe has no effect. If `ctrl_strobe_n` is also high, the edge is decided by `advance_n` alone, and `ext_addr` is not captured.
- R4: A clock edge with `ctrl_strobe_n` low captures `ext_addr` whatever the level of `bank_sel_n`. After that edge `beat_idx` is 0.
- R5: A clock edge with no active strobe and `advance_n` low increments `beat_idx` by one, modulo 4.
- R6: A clock edge with no active strobe and `advance_n` high leaves `access_addr` and `beat_idx` unchanged.
- R7: With `linear_mode` at 0 (interleaved order), `access_addr[1:0]` equals the captured low bits XOR `beat_idx`. For example, a start of 2'b10 gives 10, 11, 00, 01.
- R8: With `linear_mode` at 1 (linear order), `access_addr[1:0]` equals the captured low bits plus `beat_idx`, modulo 4. For example, a start of 2'b01 gives 01, 10, 11, 00.
- R9: `access_addr[ADDR_W-1:2]` changes only on a load. Stepping past the fourth beat wraps inside the same group and carries nothing into the upper bits.
- R10: If both strobes are active on the same edge, the load takes place and any advance request on that edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| bank_sel_n | input | 1 | Active-low bank enable; it qualifies the processor strobe |
| proc_strobe_n | input | 1 | Active-low processor address strobe |
| ctrl_strobe_n | input | 1 | Active-low controller address strobe |
| advance_n | input | 1 | Active-low beat advance; when high, the current beat is held |
| linear_mode | input | 1 | 1 selects linear wrapping order, 0 selects interleaved order |
| ext_addr | input | ADDR_W | External base address |
| access_addr | output | ADDR_W | Current access address |
| beat_idx | output | 2 | Number of the current beat within the group |

## Verification
The beat count and the captured base address are both visible at the ports. A wrong count therefore shows on `beat_idx` in the cycle after the edge that caused it. The same fault also shows in the low bits of `access_addr` in both orders. A carry leaking into the upper bits, or a load that was missed or not wanted, changes `access_addr[ADDR_W-1:2]` right after the faulty edge. The sequences are run past the fourth beat and in both modes, so that a wrap fault or a swapped order shows up within one group.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_STEP = 2'd1,
    OP_LOAD = 2'd2
  } burst_op_e;
endpackage

// File: rtl/burst_cmd_decode.sv
module burst_cmd_decode
  import burst_pkg::*;
(
  input  logic      bank_sel_n,
  input  logic      proc_strobe_n,
  input  logic      ctrl_strobe_n,
  input  logic      advance_n,
  output burst_op_e op
);
  logic proc_load;
  logic ctrl_load;

  // The processor strobe counts only when the bank enable is active.
  assign proc_load = ~proc_strobe_n & ~bank_sel_n;
  assign ctrl_load = ~ctrl_strobe_n;

  always_comb begin
    if (proc_load || ctrl_load) begin
      op = OP_LOAD;          // a load wins over any advance (R10)
    end else if (!advance_n) begin
      op = OP_STEP;
    end else begin
      op = OP_HOLD;          // wait cycle
    end
  end
endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_op_e         op,
  output logic [BEAT_W-1:0] beat_q
);
  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_d;

  always_comb begin
    unique case (op)
      OP_LOAD: beat_d = '0;
      OP_STEP: beat_d = beat_q + BEAT_ONE;   // wraps naturally
      default: beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else begin
      beat_q <= beat_d;
    end
  end

  assert_beat_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (beat_q == $past(beat_q) + BEAT_ONE));

  assert_beat_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (beat_q == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] addr_d,
  output logic [ADDR_W-1:0] addr_q
);
  logic [ADDR_W-1:0] addr_nxt;

  // The clock enable is written out explicitly as a mux.
  always_comb begin
    addr_nxt = load_en ? addr_d : addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_nxt;
    end
  end

  assert_base_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(addr_q));
endmodule

// File: rtl/burst_beat_map.sv
module burst_beat_map #(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_bits,
  input  logic [BEAT_W-1:0] beat,
  input  logic              linear_mode,
  output logic [BEAT_W-1:0] seq_bits
);
  logic [BEAT_W-1:0] ilv_bits;
  logic [BEAT_W-1:0] lin_bits;

  // Interleaved order: each bit is flipped by the matching beat bit.
  for (genvar i = 0; i < BEAT_W; i++) begin : g_ilv
    assign ilv_bits[i] = start_bits[i] ^ beat[i];
  end

  // Linear order: add modulo 2**BEAT_W.
  assign lin_bits = start_bits + beat;

  always_comb begin
    seq_bits = linear_mode ? lin_bits : ilv_bits;
  end

  always_comb begin
    assert_beat0_start_R7: assert (beat != '0 || seq_bits == start_bits);
  end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel_n,
  input  logic              proc_strobe_n,
  input  logic              ctrl_strobe_n,
  input  logic              advance_n,
  input  logic              linear_mode,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] access_addr,
  output logic [1:0]        beat_idx
);
  localparam int BEAT_W = 2;

  burst_op_e         op;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;

  burst_cmd_decode u_dec (
    .bank_sel_n    (bank_sel_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .op            (op)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (op == OP_LOAD),
    .addr_d  (ext_addr),
    .addr_q  (base_q)
  );

  burst_beat_counter #(.BEAT_W(BEAT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .beat_q (beat_q)
  );

  burst_beat_map #(.BEAT_W(BEAT_W)) u_map (
    .start_bits  (base_q[BEAT_W-1:0]),
    .beat        (beat_q),
    .linear_mode (linear_mode),
    .seq_bits    (low_bits)
  );

  assign access_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};
  assign beat_idx    = beat_q;

  assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_strobe_n && !bank_sel_n) |=> (access_addr == $past(ext_addr) && beat_idx == 2'd0));

  assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_strobe_n |=> (access_addr == $past(ext_addr) && beat_idx == 2'd0));

  assert_wait_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_strobe_n && (proc_strobe_n || bank_sel_n) && advance_n && $stable(linear_mode))
      |=> ($stable(access_addr) && $stable(beat_idx)));

  assert_no_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_strobe_n && (proc_strobe_n || bank_sel_n))
      |=> (access_addr[ADDR_W-1:2] == $past(access_addr[ADDR_W-1:2])));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_strobe_n && !proc_strobe_n && !advance_n) |=> (beat_idx == 2'd0));
endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;
  localparam int AW = 17;
  localparam int NV = 15;
  // Fields: req[4], proc_n, ctrl_n, bank_n, adv_n, mode, ext[17], exp_addr[17], exp_beat[2]
  localparam int VW = 4 + 5 + AW + AW + 2;

  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  5'b0_1_0_1_0, 17'h0F0F2, 17'h0F0F2, 2'd0}, // R2 load via processor strobe
    {4'd7,  5'b1_1_1_0_0, 17'h00000, 17'h0F0F3, 2'd1}, // R7 R5 10^01
    {4'd7,  5'b1_1_1_0_0, 17'h00000, 17'h0F0F0, 2'd2}, // R7
    {4'd7,  5'b1_1_1_0_0, 17'h00000, 17'h0F0F1, 2'd3}, // R7
    {4'd6,  5'b1_1_1_1_0, 17'h1AAAA, 17'h0F0F1, 2'd3}, // R6 wait cycle
    {4'd9,  5'b1_1_1_0_0, 17'h00000, 17'h0F0F2, 2'd0}, // R9 R5 wrap
    {4'd4,  5'b1_0_1_1_1, 17'h12345, 17'h12345, 2'd0}, // R4 ctrl load, bank off
    {4'd8,  5'b1_1_1_0_1, 17'h00000, 17'h12346, 2'd1}, // R8
    {4'd8,  5'b1_1_1_0_1, 17'h00000, 17'h12347, 2'd2}, // R8
    {4'd9,  5'b1_1_1_0_1, 17'h00000, 17'h12344, 2'd3}, // R9 no carry
    {4'd5,  5'b1_1_1_0_1, 17'h00000, 17'h12345, 2'd0}, // R5 wrap
    {4'd3,  5'b0_1_1_0_1, 17'h00000, 17'h12346, 2'd1}, // R3 gated strobe
    {4'd10, 5'b0_0_0_0_1, 17'h1FFFF, 17'h1FFFF, 2'd0}, // R10 load wins
    {4'd9,  5'b1_1_1_0_1, 17'h00000, 17'h1FFFC, 2'd1}, // R9 11+1 wraps
    {4'd7,  5'b1_1_1_1_0, 17'h00000, 17'h1FFFE, 2'd1}  // R7 interleave view
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bank_sel_n, proc_strobe_n, ctrl_strobe_n, advance_n, linear_mode;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] access_addr;
  logic [1:0]    beat_idx;
  int            checks = 0;
  int            errors = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_sel_n    (bank_sel_n),
    .proc_strobe_n (proc_strobe_n),
    .ctrl_strobe_n (ctrl_strobe_n),
    .advance_n     (advance_n),
    .linear_mode   (linear_mode),
    .ext_addr      (ext_addr),
    .access_addr   (access_addr),
    .beat_idx      (beat_idx)
  );

  task automatic check(input int req, input logic [AW-1:0] ea, input logic [1:0] eb);
    checks++;
    if (access_addr !== ea || beat_idx !== eb) begin
      errors++;
      $display("FAIL R%0d: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, access_addr, beat_idx, ea, eb);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run hung");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bank_sel_n = 1'b1; proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1;
    advance_n = 1'b1; linear_mode = 1'b0; ext_addr = '0;
    repeat (2) @(negedge clk);
    check(1, '0, 2'd0); // R1 reset state
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      proc_strobe_n = VEC[i][VW-5];
      ctrl_strobe_n = VEC[i][VW-6];
      bank_sel_n    = VEC[i][VW-7];
      advance_n     = VEC[i][VW-8];
      linear_mode   = VEC[i][VW-9];
      ext_addr      = VEC[i][2*AW+1:AW+2];
      @(posedge clk);
      #1;
      check(int'(VEC[i][VW-1:VW-4]), VEC[i][AW+1:2], VEC[i][1:0]);
    end

    // R1: asynchronous reset in the middle of a group clears at once
    @(negedge clk);
    proc_strobe_n = 1'b1; ctrl_strobe_n = 1'b1; advance_n = 1'b0;
    rst_n = 1'b0;
    #1;
    check(1, '0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    advance_n = 1'b1;

    // R6: a long wait after a step holds the address
    @(negedge clk);
    ctrl_strobe_n = 1'b0; ext_addr = 17'h00A01; linear_mode = 1'b1;
    @(negedge clk);
    ctrl_strobe_n = 1'b1; advance_n = 1'b0;
    @(negedge clk);
    advance_n = 1'b1; ext_addr = 17'h1F00F;
    repeat (3) @(negedge clk);
    check(6, 17'h00A02, 2'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule